// File: doc/BRIEF.md
# Half-precision to signed integer converter

The block takes one 16-bit binary floating-point value in half-precision layout and turns it into a two's-complement signed integer. The conversion always drops any fractional part, so every result is rounded toward zero. The destination is either 32 or 64 bits wide. A width-select bit asks for the wide result, but the request is only honoured while a long-mode input is high. In every other case the block behaves as if the narrow width had been requested.

Besides the integer, the block reports two exception flags: invalid and inexact. Infinities and NaNs cannot be represented as integers, so they are invalid and produce the fixed "integer indefinite" pattern. That pattern has only the sign bit of the destination set. When the invalid mask is clear, a trap request output is also raised so that logic outside the block can take an exception. A suppress input silences all exception reporting and leaves the result unchanged. The outputs are registered, so a result appears one clock after its operand.

Top module: `half_to_int_trunc`

## Requirements
- R1: The integer result equals the input value rounded toward zero for both signs. For example, 1.5 gives 1, -1.5 gives -1 and -2.75 gives -2.
- R2: `flag_inexact` is 1 exactly when a finite input has a nonzero fractional part and `suppress_all` is 0. Inputs that are whole numbers leave it at 0.
- R3: An exponent field (`op_bits[14:10]`) of 5'h1F encodes infinity or NaN. Either one sets `flag_invalid` (unless suppressed) and never sets `flag_inexact`.
- R4: An invalid input produces the indefinite pattern. In the 64-bit form this is 64'h8000_0000_0000_0000. In the 32-bit form it is 64'h0000_0000_8000_0000.
- R5: `trap_req` is 1 exactly when the input is invalid, `inv_mask` is 0 and `suppress_all` is 0. The result is the indefinite pattern whether or not the trap is requested.
- R6: A 64-bit result is produced only when both `long_mode` and `wide_sel` are 1. Otherwise the low 32 bits hold the 32-bit two's-complement result and bits 63:32 are 0.
- R7: With `suppress_all` at 1, `flag_invalid`, `flag_inexact` and `trap_req` are all 0, and the result is unchanged.
- R8: Subnormal inputs (exponent field 0, fraction nonzero) give 0 with the inexact flag set. Positive and negative zero give 0 with no flags.
- R9: The largest finite magnitude, 65504 (0x7BFF and 0xFBFF), converts exactly to +65504 and -65504 with no flags.
- R10: The outputs change one clock edge after the operand is sampled. While `rst_n` is 0, the result, both flags and `trap_req` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_bits | input | 16 | Half-precision operand: sign [15], exponent [14:10], fraction [9:0] |
| wide_sel | input | 1 | Requests a 64-bit destination |
| long_mode | input | 1 | Enables honouring of `wide_sel` |
| inv_mask | input | 1 | 1 masks the invalid exception (no trap request) |
| suppress_all | input | 1 | 1 suppresses all exception reporting |
| result | output | 64 | Converted integer, or the indefinite pattern |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Precision (inexact) flag |
| trap_req | output | 1 | Unmasked invalid exception request |

## Verification
Four kinds of operand are used, and each one singles out a different part of the converter.

- **Whole numbers and non-integers of both signs.** These separate a proper truncation from a floor or a rounding, and an exact conversion from an inexact one.
- **Subnormals, signed zeros and the largest finite value.** These probe the two ends of the shifter: the path that bypasses the shift entirely, and the maximum shift.
- **Infinities and NaNs under every mask and suppress combination.** These separate the result path from the flag gating.
- **The same negative value in all three mode and width combinations.** This shows whether sign extension reaches bit 63 only when the wide form is truly selected.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

  // Operand class seen by the magnitude and packing stages.
  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUBNORM = 2'd1,
    CLS_NORMAL  = 2'd2,
    CLS_SPECIAL = 2'd3
  } hcvt_cls_e;

  localparam int unsigned HALF_EXP_W  = 5;
  localparam int unsigned HALF_FRAC_W = 10;
  localparam int unsigned HALF_BIAS   = 15;

endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify #(
  parameter int unsigned EXP_W  = 5,
  parameter int unsigned FRAC_W = 10,
  localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [OP_W-1:0]   op,
  output logic              sign,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W-1:0] frac_f,
  output hcvt_pkg::hcvt_cls_e cls
);

  function automatic hcvt_pkg::hcvt_cls_e classify(
    input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    if (&e)        return hcvt_pkg::CLS_SPECIAL;
    else if (e != '0) return hcvt_pkg::CLS_NORMAL;
    else if (f != '0) return hcvt_pkg::CLS_SUBNORM;
    else           return hcvt_pkg::CLS_ZERO;
  endfunction

  always_comb begin
    sign   = op[OP_W-1];
    exp_f  = op[OP_W-2 -: EXP_W];
    frac_f = op[FRAC_W-1:0];
    cls    = classify(exp_f, frac_f);
  end

endmodule

// File: rtl/hcvt_magnitude.sv
module hcvt_magnitude #(
  parameter int unsigned EXP_W  = 5,
  parameter int unsigned FRAC_W = 10,
  parameter int unsigned BIAS   = 15,
  parameter int unsigned MAG_W  = 16,
  localparam int unsigned EXT_W = MAG_W + FRAC_W
) (
  input  logic [EXP_W-1:0]    exp_f,
  input  logic [FRAC_W-1:0]   frac_f,
  input  hcvt_pkg::hcvt_cls_e cls,
  output logic [MAG_W-1:0]    mag,
  output logic                lost_bits
);

  // Returns {lost, integer magnitude} after dropping the fraction.
  function automatic logic [MAG_W:0] trunc_mag(
    input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f, input logic norm);
    logic [EXT_W-1:0] ext;
    int unb;
    ext = '0;
    ext[FRAC_W:0] = {norm, f};
    if (!norm) return {(f != '0), {MAG_W{1'b0}}};
    unb = int'(e) - int'(BIAS);
    if (unb < 0) return {1'b1, {MAG_W{1'b0}}};
    ext = ext << unb;
    return {(ext[FRAC_W-1:0] != '0), ext[EXT_W-1:FRAC_W]};
  endfunction

  logic [MAG_W:0] packed_out;

  always_comb begin
    packed_out = trunc_mag(exp_f, frac_f, cls == hcvt_pkg::CLS_NORMAL);
    if (cls == hcvt_pkg::CLS_SPECIAL) packed_out = '0;
    mag       = packed_out[MAG_W-1:0];
    lost_bits = packed_out[MAG_W];
  end

endmodule

// File: rtl/hcvt_pack.sv
module hcvt_pack #(
  parameter int unsigned MAG_W    = 16,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64
) (
  input  logic              sign,
  input  logic [MAG_W-1:0]  mag,
  input  logic              lost_bits,
  input  logic              is_special,
  input  logic              use_wide,
  input  logic              inv_mask,
  input  logic              suppress_all,
  output logic [WIDE_W-1:0] result,
  output logic              raw_invalid,
  output logic              flag_invalid,
  output logic              flag_inexact,
  output logic              trap_req
);

  // True when the magnitude with its sign fits a signed field of w bits.
  function automatic logic fits(input logic [MAG_W-1:0] m, input logic neg, input int w);
    logic [WIDE_W:0] lim;
    logic [WIDE_W:0] mx;
    lim = ({{WIDE_W{1'b0}}, 1'b1} << (w - 1)) - {{WIDE_W{1'b0}}, !neg};
    mx  = {{(WIDE_W + 1 - MAG_W){1'b0}}, m};
    return mx <= lim;
  endfunction

  function automatic logic [WIDE_W-1:0] indefinite(input logic wide);
    logic [WIDE_W-1:0] v;
    v = '0;
    if (wide) v[WIDE_W-1] = 1'b1;
    else      v[NARROW_W-1] = 1'b1;
    return v;
  endfunction

  logic [WIDE_W-1:0] ext_mag;
  logic [WIDE_W-1:0] signed_val;
  logic              in_range;

  always_comb begin
    ext_mag    = {{(WIDE_W - MAG_W){1'b0}}, mag};
    signed_val = sign ? (~ext_mag + 1'b1) : ext_mag;
    in_range   = fits(mag, sign, use_wide ? int'(WIDE_W) : int'(NARROW_W));
    raw_invalid = is_special || !in_range;
    if (raw_invalid)   result = indefinite(use_wide);
    else if (use_wide) result = signed_val;
    else               result = {{(WIDE_W - NARROW_W){1'b0}}, signed_val[NARROW_W-1:0]};
    flag_invalid = raw_invalid && !suppress_all;
    flag_inexact = lost_bits && !raw_invalid && !suppress_all;
    trap_req     = raw_invalid && !inv_mask && !suppress_all;
  end

endmodule

// File: rtl/half_to_int_trunc.sv
module half_to_int_trunc #(
  parameter int unsigned EXP_W    = hcvt_pkg::HALF_EXP_W,
  parameter int unsigned FRAC_W   = hcvt_pkg::HALF_FRAC_W,
  parameter int unsigned BIAS     = hcvt_pkg::HALF_BIAS,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64,
  localparam int unsigned OP_W    = 1 + EXP_W + FRAC_W,
  localparam int unsigned MAX_UNB = (1 << EXP_W) - 2 - BIAS,
  localparam int unsigned MAG_W   = MAX_UNB + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_bits,
  input  logic              wide_sel,
  input  logic              long_mode,
  input  logic              inv_mask,
  input  logic              suppress_all,
  output logic [WIDE_W-1:0] result,
  output logic              flag_invalid,
  output logic              flag_inexact,
  output logic              trap_req
);

  // Named internal events, also observed by the bound checker.
  logic                sgn;
  logic [EXP_W-1:0]    ev_exp;
  logic [FRAC_W-1:0]   ev_frac;
  hcvt_pkg::hcvt_cls_e ev_cls;
  logic [MAG_W-1:0]    ev_mag;
  logic                ev_lost_bits;
  logic                ev_special;
  logic                ev_use_wide;
  logic                ev_invalid;

  logic [WIDE_W-1:0]   nxt_result;
  logic                nxt_inv, nxt_inx, nxt_trap;

  assign ev_special  = (ev_cls == hcvt_pkg::CLS_SPECIAL);
  assign ev_use_wide = long_mode && wide_sel;

  hcvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .op(op_bits), .sign(sgn), .exp_f(ev_exp), .frac_f(ev_frac), .cls(ev_cls)
  );

  hcvt_magnitude #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS), .MAG_W(MAG_W)) u_mag (
    .exp_f(ev_exp), .frac_f(ev_frac), .cls(ev_cls), .mag(ev_mag), .lost_bits(ev_lost_bits)
  );

  hcvt_pack #(.MAG_W(MAG_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_pack (
    .sign(sgn), .mag(ev_mag), .lost_bits(ev_lost_bits), .is_special(ev_special),
    .use_wide(ev_use_wide), .inv_mask(inv_mask), .suppress_all(suppress_all),
    .result(nxt_result), .raw_invalid(ev_invalid), .flag_invalid(nxt_inv),
    .flag_inexact(nxt_inx), .trap_req(nxt_trap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      trap_req     <= 1'b0;
    end else begin
      result       <= nxt_result;
      flag_invalid <= nxt_inv;
      flag_inexact <= nxt_inx;
      trap_req     <= nxt_trap;
    end
  end

endmodule

// File: rtl/half_to_int_trunc_chk.sv
module half_to_int_trunc_chk #(
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wide_sel,
  input logic              long_mode,
  input logic              inv_mask,
  input logic              suppress_all,
  input logic              ev_lost_bits,
  input logic              ev_special,
  input logic [WIDE_W-1:0] result,
  input logic              flag_invalid,
  input logic              flag_inexact,
  input logic              trap_req
);

  localparam logic [WIDE_W-1:0] INDEF_W = {1'b1, {(WIDE_W-1){1'b0}}};
  localparam logic [WIDE_W-1:0] INDEF_N = {{(WIDE_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  a_r2_quiet_when_exact: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_lost_bits |=> !flag_inexact);

  a_r3_special_no_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    ev_special |=> !flag_inexact && (flag_invalid || $past(suppress_all)));

  a_r4_invalid_indefinite: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (result == INDEF_W || result == INDEF_N));

  a_r5_trap_unmasked_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_mask || suppress_all) |=> !trap_req || flag_invalid);

  a_r5_trap_needs_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    inv_mask |=> !trap_req);

  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(long_mode && wide_sel) |=> result[WIDE_W-1:NARROW_W] == '0);

  a_r7_suppress_silences: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_all |=> !flag_invalid && !flag_inexact && !trap_req);

endmodule

bind half_to_int_trunc half_to_int_trunc_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel), .long_mode(long_mode),
  .inv_mask(inv_mask), .suppress_all(suppress_all), .ev_lost_bits(ev_lost_bits),
  .ev_special(ev_special), .result(result), .flag_invalid(flag_invalid),
  .flag_inexact(flag_inexact), .trap_req(trap_req)
);

// File: tb/half_to_int_trunc_bench.sv
module half_to_int_trunc_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_bits = '0;
  logic        wide_sel = 1'b0, long_mode = 1'b0, inv_mask = 1'b1, suppress_all = 1'b0;
  logic [63:0] result;
  logic        flag_invalid, flag_inexact, trap_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        inv, inx, trap;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  half_to_int_trunc u_half_to_int_trunc (
    .clk(clk), .rst_n(rst_n), .op_bits(op_bits), .wide_sel(wide_sel),
    .long_mode(long_mode), .inv_mask(inv_mask), .suppress_all(suppress_all),
    .result(result), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .trap_req(trap_req)
  );

  // Reference: value as a real number, truncated by $rtoi.
  function automatic exp_t model(input logic [15:0] op, input logic w, input logic lm,
                                 input logic msk, input logic sup, input string tag);
    exp_t x;
    logic [4:0] e;
    logic [9:0] f;
    logic       wide;
    real        v, sc;
    longint     ip, sv;
    int         p;
    e = op[14:10]; f = op[9:0];
    wide = w && lm;
    x.tag = tag;
    if (e == 5'h1F) begin
      x.res  = wide ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      x.inv  = !sup;
      x.inx  = 1'b0;
      x.trap = !sup && !msk;
    end else begin
      v  = (e == 0) ? real'(f) : real'(1024 + int'(f));
      p  = ((e == 0) ? 1 : int'(e)) - 25;
      sc = 1.0;
      for (int k = 0; k < ((p < 0) ? -p : p); k++) sc = sc * 2.0;
      v  = (p < 0) ? v / sc : v * sc;
      ip = $rtoi(v);
      sv = op[15] ? -ip : ip;
      x.res  = wide ? 64'(sv) : {32'h0, 32'(sv)};
      x.inv  = 1'b0;
      x.inx  = !sup && ($itor(ip) != v);
      x.trap = 1'b0;
    end
    return x;
  endfunction

  task automatic apply(input logic [15:0] op, input logic w, input logic lm,
                       input logic msk, input logic sup, input string tag);
    @(negedge clk);
    op_bits = op; wide_sel = w; long_mode = lm; inv_mask = msk; suppress_all = sup;
    sb.push_back(model(op, w, lm, msk, sup, tag));
  endtask

  // Monitor: one result per posedge after each driven operand.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_cmp++;
        if (result !== x.res || flag_invalid !== x.inv || flag_inexact !== x.inx
            || trap_req !== x.trap) begin
          n_bad++;
          $display("FAIL %s: got res=%h inv=%b inx=%b trap=%b, expected res=%h inv=%b inx=%b trap=%b",
                   x.tag, result, flag_invalid, flag_inexact, trap_req,
                   x.res, x.inv, x.inx, x.trap);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    op_bits = 16'hFBFF; wide_sel = 1'b1; long_mode = 1'b1; suppress_all = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (result !== 64'h0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0 || trap_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R10 reset: got res=%h inv=%b inx=%b trap=%b, expected all zero",
               result, flag_invalid, flag_inexact, trap_req);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 truncation, both signs (narrow form)
    apply(16'h3E00, 0, 0, 1, 0, "R1 +1.5");
    apply(16'hBE00, 0, 0, 1, 0, "R1 -1.5");
    apply(16'hC180, 0, 1, 1, 0, "R1 -2.75");
    apply(16'hC180, 1, 1, 1, 0, "R1 -2.75 wide");
    apply(16'h3BFF, 0, 0, 1, 0, "R1 just below one");
    // R2 exact versus inexact
    apply(16'h4400, 0, 0, 1, 0, "R2 exact 4.0");
    apply(16'h5640, 1, 1, 1, 0, "R2 exact 100");
    apply(16'h3C01, 0, 0, 1, 0, "R2 inexact 1+ulp");
    // R3/R4 invalid encodings, masked
    apply(16'h7C00, 0, 0, 1, 0, "R3 +inf narrow");
    apply(16'hFC00, 1, 1, 1, 0, "R4 -inf wide indefinite");
    apply(16'h7E00, 1, 0, 1, 0, "R4 qNaN mode off narrow");
    apply(16'h7C01, 0, 1, 1, 0, "R3 sNaN");
    // R5 unmasked invalid
    apply(16'h7C00, 1, 1, 0, 0, "R5 +inf unmasked wide");
    apply(16'hFE00, 0, 0, 0, 0, "R5 NaN unmasked narrow");
    apply(16'h3E00, 0, 0, 0, 0, "R5 finite unmasked no trap");
    // R6 width selection on -1.0
    apply(16'hBC00, 1, 1, 1, 0, "R6 wide -1");
    apply(16'hBC00, 1, 0, 1, 0, "R6 sel without mode -1");
    apply(16'hBC00, 0, 1, 1, 0, "R6 mode without sel -1");
    // R7 suppression
    apply(16'h3E00, 0, 0, 1, 1, "R7 suppressed inexact");
    apply(16'h7E00, 1, 1, 0, 1, "R7 suppressed unmasked NaN");
    apply(16'hC180, 1, 1, 0, 1, "R7 suppressed -2.75 wide");
    // R8 subnormals and zeros
    apply(16'h0001, 0, 0, 1, 0, "R8 smallest subnormal");
    apply(16'h83FF, 1, 1, 1, 0, "R8 negative subnormal");
    apply(16'h0000, 0, 0, 1, 0, "R8 +zero");
    apply(16'h8000, 1, 1, 1, 0, "R8 -zero");
    // R9 largest finite
    apply(16'h7BFF, 1, 1, 1, 0, "R9 +65504");
    apply(16'hFBFF, 1, 1, 1, 0, "R9 -65504 wide");
    apply(16'hFBFF, 0, 0, 1, 0, "R9 -65504 narrow");
    // R10 back-to-back stream: each result one edge after its operand
    for (int i = 0; i < 16; i++)
      apply({1'b0, 5'(15 + i), 10'(i * 37)}, 1'b1, 1'b1, 1'b1, 1'b0, "R10 stream");

    repeat (4) @(posedge clk);
    #1;
    finish_run();
  end

endmodule